// File: doc/BRIEF.md
# Micro-Program Sequencer with Branch Delay Slots

This block walks a control store of 37-bit micro-instructions and presents the word at the current micro-address to the datapath, both as a raw word and split into its fields. After every micro-op it works out the next address. That address is the next sequential one, the target of a micro-jump, the entry point of the next decoded instruction, or a redirect target requested by a protection checker.

Every taken jump and every end-of-instruction (next-entry) op is followed by exactly one delay-slot micro-op. The delay-slot op runs before control moves. Entry points come from a three-deep FIFO that an instruction decoder fills through a valid/ready port. A protection redirect is accepted at any time. It lands after exactly three more micro-ops have executed.

A stall input freezes the whole sequencer. The control store is a parameter, and its default image is a small test program computed in the package.

Top module: `useq_sequencer`

## Requirements
- R1: Word layout, from bit 36 down: sequencing op [36:35] (0 step, 1 jump, 2 conditional jump, 3 next-entry), condition select [34:32], jump target [31:26], move source [25:21], move destination [20:16], ALU source [15:13], ALU op [12:9], sub-op [8:6], bus control [5:0]. In the default image, address a holds source a[4:0], destination ~a[4:0], ALU source a[2:0], ALU op a[3:0], sub-op a[5:3] and bus a[5:0]. The field ports always show the fields of the word at `upc_o`.
- R2: Reset sets the micro-address to RESET_ADDR (default 0) and empties the entry FIFO (`entry_ready_o` high). It also clears any delay slot, wait or pending redirect.
- R3: An op that causes no transfer is followed by the op at the next address.
- R4: A jump (in the default image, address 1 jumps to 8) executes the op at the following address as a delay slot, with `slot_o` high, before the target runs.
- R5: A conditional jump is taken only when `cond_i[select]` is 1. In the default image, address 8 tests bit 0 and targets 16. When the condition is 0, execution continues sequentially (8, 9, 10).
- R6: A next-entry op (default addresses 11, 16, 32, 48, 60) runs its delay slot. The sequencer then continues at the FIFO's oldest entry, in push order. An instruction at entry 32 takes exactly two micro-ops.
- R7: A transfer op that sits in a delay slot is ignored. In the default image, 41 jumps to 56 while serving as the slot of 40's jump to 48, so execution goes to 48.
- R8: If the FIFO is empty when a delay slot of a next-entry op finishes, no micro-op executes (`uop_valid_o` low) until an entry is pushed.
- R9: The FIFO holds three entries. When it is full, `entry_ready_o` is low and a push is dropped.
- R10: A redirect raised while a micro-op executes lets exactly three further micro-ops execute, and the next one is at the redirect address. That op is not a delay slot.
- R11: A redirect landing in the same cycle as a pending jump or delay-slot transfer wins.
- R12: A redirect raised while another is pending is ignored.
- R13: While `stall_i` is high, `uop_valid_o` is low and the micro-address, delay-slot state and redirect countdown hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze the sequencer this cycle |
| cond_i | input | 8 | Condition bits tested by conditional jumps |
| entry_valid_i | input | 1 | Decoder offers an entry address |
| entry_addr_i | input | 6 | Entry micro-address |
| entry_ready_o | output | 1 | FIFO has room |
| redirect_i | input | 1 | Protection redirect request |
| redirect_addr_i | input | 6 | Redirect target |
| uop_valid_o | output | 1 | The presented micro-op executes this cycle |
| upc_o | output | 6 | Current micro-address |
| slot_o | output | 1 | Current op is a delay slot |
| uword_o | output | 37 | Raw micro-instruction |
| move_src_o | output | 5 | Move source field |
| move_dst_o | output | 5 | Move destination field |
| alu_src_o | output | 3 | ALU source field |
| alu_op_o | output | 4 | ALU op field |
| sub_op_o | output | 3 | Sub-operation field |
| bus_ctl_o | output | 6 | Bus control field |

## Verification
The hardest cases are those where a redirect's third micro-op is itself a jump or a delay slot about to transfer. The collision depends on the exact cycle in which the request is raised. The stimulus therefore watches `upc_o` and raises the redirect in the cycle a chosen address executes. It does this once at address 0, so that the landing falls on the conditional jump at 8. It does this again at address 1, so that the landing falls on the delay slot at 9. A stall window is inserted while a countdown is pending, and a second request is raised during a countdown. A scoreboard holds the expected sequence of addresses and slot flags for each case.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UWORD_W = 37;
    localparam int UADDR_W = 6;
    localparam int UDEPTH  = 1 << UADDR_W;
    localparam int COND_W  = 8;
    localparam int CSEL_W  = $clog2(COND_W);

    typedef enum logic [1:0] {
        SEQ_STEP  = 2'd0,
        SEQ_JUMP  = 2'd1,
        SEQ_CJUMP = 2'd2,
        SEQ_NEXT  = 2'd3
    } seq_op_e;

    typedef struct packed {
        seq_op_e              seq;
        logic [CSEL_W-1:0]    csel;
        logic [UADDR_W-1:0]   target;
        logic [4:0]           src;
        logic [4:0]           dst;
        logic [2:0]           alu_src;
        logic [3:0]           alu_op;
        logic [2:0]           sub_op;
        logic [5:0]           bus;
    } uword_t;

    typedef logic [UDEPTH-1:0][UWORD_W-1:0] rom_image_t;

    // Non-control fields derived from the address, sequential step
    function automatic uword_t plain_word(input int a);
        uword_t            w;
        logic [5:0]        aa;
        aa        = 6'(a);
        w.seq     = SEQ_STEP;
        w.csel    = '0;
        w.target  = '0;
        w.src     = aa[4:0];
        w.dst     = ~aa[4:0];
        w.alu_src = aa[2:0];
        w.alu_op  = aa[3:0];
        w.sub_op  = aa[5:3];
        w.bus     = aa;
        return w;
    endfunction

    function automatic uword_t ctl_word(input int a, input seq_op_e op,
                                        input int cs, input int tgt);
        uword_t w;
        w        = plain_word(a);
        w.seq    = op;
        w.csel   = CSEL_W'(cs);
        w.target = UADDR_W'(tgt);
        return w;
    endfunction

    // Small test program used as the default control store
    function automatic rom_image_t demo_rom();
        rom_image_t img;
        for (int a = 0; a < UDEPTH; a++) begin
            img[a] = plain_word(a);
        end
        img[1]  = ctl_word(1,  SEQ_JUMP,  0, 8);
        img[8]  = ctl_word(8,  SEQ_CJUMP, 0, 16);
        img[11] = ctl_word(11, SEQ_NEXT,  0, 0);
        img[16] = ctl_word(16, SEQ_NEXT,  0, 0);
        img[32] = ctl_word(32, SEQ_NEXT,  0, 0);
        img[40] = ctl_word(40, SEQ_JUMP,  0, 48);
        img[41] = ctl_word(41, SEQ_JUMP,  0, 56);
        img[48] = ctl_word(48, SEQ_NEXT,  0, 0);
        img[60] = ctl_word(60, SEQ_NEXT,  0, 0);
        return img;
    endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
#(
    parameter rom_image_t IMAGE = demo_rom()
) (
    input  logic [UADDR_W-1:0] addr_i,
    output uword_t             word_o
);
    assign word_o = uword_t'(IMAGE[addr_i]);
endmodule

// File: rtl/useq_entry_fifo.sv
module useq_entry_fifo #(
    parameter int DEPTH = 3,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    output logic         ready_o,
    input  logic         pop_i,
    output logic         has_o,
    output logic [W-1:0] head_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;
    logic          push;

    assign ready_o = (count_q != CW'(DEPTH));
    assign has_o   = (count_q != '0);
    assign push    = valid_i && ready_o;
    assign head_o  = mem_q[rd_q];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[i] <= '0;
            end else if (push && wr_q == PW'(i)) begin
                mem_q[i] <= data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push)  wr_q <= bump(wr_q);
            if (pop_i) rd_q <= bump(rd_q);
            if (push && !pop_i)      count_q <= count_q + CW'(1);
            else if (!push && pop_i) count_q <= count_q - CW'(1);
        end
    end

    // R6
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> count_q != '0);
    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i && !pop_i && count_q == CW'(DEPTH) |=> count_q == CW'(DEPTH));
    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));
endmodule

// File: rtl/useq_redirect.sv
module useq_redirect #(
    parameter int LAT = 3,
    parameter int AW  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raise_i,
    input  logic [AW-1:0] addr_i,
    input  logic          advance_i,
    output logic          fire_o,
    output logic [AW-1:0] tgt_o
);
    localparam int CW = $clog2(LAT + 1);

    logic          pending_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] tgt_q;

    assign fire_o = pending_q && advance_i && (cnt_q == CW'(1));
    assign tgt_o  = tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            cnt_q     <= '0;
            tgt_q     <= '0;
        end else if (!pending_q) begin
            if (raise_i) begin
                pending_q <= 1'b1;
                cnt_q     <= CW'(LAT);
                tgt_q     <= addr_i;
            end
        end else if (advance_i) begin
            if (cnt_q == CW'(1)) begin
                pending_q <= 1'b0;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // R10
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        pending_q |-> (cnt_q != '0 && cnt_q <= CW'(LAT)));
    // R12
    second_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        pending_q && raise_i |=> $stable(tgt_q));
    // R13
    frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
        pending_q && !advance_i && !raise_i |=> $stable(cnt_q) && pending_q);
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int                 FIFO_DEPTH   = 3,
    parameter int                 REDIRECT_LAT = 3,
    parameter logic [UADDR_W-1:0] RESET_ADDR   = '0,
    parameter rom_image_t         ROM_IMAGE    = demo_rom()
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall_i,
    input  logic [COND_W-1:0]  cond_i,
    input  logic               entry_valid_i,
    input  logic [UADDR_W-1:0] entry_addr_i,
    output logic               entry_ready_o,
    input  logic               redirect_i,
    input  logic [UADDR_W-1:0] redirect_addr_i,
    output logic               uop_valid_o,
    output logic [UADDR_W-1:0] upc_o,
    output logic               slot_o,
    output logic [UWORD_W-1:0] uword_o,
    output logic [4:0]         move_src_o,
    output logic [4:0]         move_dst_o,
    output logic [2:0]         alu_src_o,
    output logic [3:0]         alu_op_o,
    output logic [2:0]         sub_op_o,
    output logic [5:0]         bus_ctl_o
);
    logic [UADDR_W-1:0] upc_q, upc_d;
    logic               slot_q, slot_d;
    logic [UADDR_W-1:0] slot_tgt_q, slot_tgt_d;
    logic               slot_next_q, slot_next_d;
    logic               wait_q, wait_d;

    uword_t             cur_w;
    logic               exec, cond_hit, xfer_req;
    logic               rd_fire;
    logic [UADDR_W-1:0] rd_tgt;
    logic               fifo_has, fifo_pop;
    logic [UADDR_W-1:0] fifo_head;

    useq_rom #(.IMAGE(ROM_IMAGE)) u_rom (
        .addr_i (upc_q),
        .word_o (cur_w)
    );

    useq_entry_fifo #(.DEPTH(FIFO_DEPTH), .W(UADDR_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .valid_i (entry_valid_i),
        .data_i  (entry_addr_i),
        .ready_o (entry_ready_o),
        .pop_i   (fifo_pop),
        .has_o   (fifo_has),
        .head_o  (fifo_head)
    );

    useq_redirect #(.LAT(REDIRECT_LAT), .AW(UADDR_W)) u_redirect (
        .clk       (clk),
        .rst       (rst),
        .raise_i   (redirect_i),
        .addr_i    (redirect_addr_i),
        .advance_i (exec),
        .fire_o    (rd_fire),
        .tgt_o     (rd_tgt)
    );

    assign exec     = !stall_i && !wait_q;
    assign cond_hit = cond_i[cur_w.csel];
    assign xfer_req = !slot_q && ((cur_w.seq == SEQ_JUMP) || (cur_w.seq == SEQ_NEXT) ||
                                  (cur_w.seq == SEQ_CJUMP && cond_hit));
    assign fifo_pop = fifo_has &&
                      ((wait_q && !stall_i) ||
                       (exec && !rd_fire && slot_q && slot_next_q));

    always_comb begin
        upc_d       = upc_q;
        slot_d      = slot_q;
        slot_tgt_d  = slot_tgt_q;
        slot_next_d = slot_next_q;
        wait_d      = wait_q;
        if (wait_q) begin
            if (!stall_i && fifo_has) begin
                upc_d  = fifo_head;
                wait_d = 1'b0;
            end
        end else if (exec) begin
            if (rd_fire) begin
                upc_d  = rd_tgt;
                slot_d = 1'b0;
            end else if (slot_q) begin
                slot_d = 1'b0;
                if (slot_next_q) begin
                    if (fifo_has) upc_d  = fifo_head;
                    else          wait_d = 1'b1;
                end else begin
                    upc_d = slot_tgt_q;
                end
            end else begin
                upc_d = upc_q + UADDR_W'(1);
                if (xfer_req) begin
                    slot_d      = 1'b1;
                    slot_tgt_d  = cur_w.target;
                    slot_next_d = (cur_w.seq == SEQ_NEXT);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upc_q       <= RESET_ADDR;
            slot_q      <= 1'b0;
            slot_tgt_q  <= '0;
            slot_next_q <= 1'b0;
            wait_q      <= 1'b0;
        end else begin
            upc_q       <= upc_d;
            slot_q      <= slot_d;
            slot_tgt_q  <= slot_tgt_d;
            slot_next_q <= slot_next_d;
            wait_q      <= wait_d;
        end
    end

    assign uop_valid_o = exec;
    assign upc_o       = upc_q;
    assign slot_o      = slot_q;
    assign uword_o     = cur_w;
    assign move_src_o  = cur_w.src;
    assign move_dst_o  = cur_w.dst;
    assign alu_src_o   = cur_w.alu_src;
    assign alu_op_o    = cur_w.alu_op;
    assign sub_op_o    = cur_w.sub_op;
    assign bus_ctl_o   = cur_w.bus;

    // R2
    reset_entry_chk: assert property (@(posedge clk)
        $fell(rst) |-> (upc_q == RESET_ADDR && !slot_q && !wait_q));
    // R13
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(upc_q) && $stable(slot_q));
    // R4
    slot_follows_chk: assert property (@(posedge clk) disable iff (rst)
        exec && xfer_req && !rd_fire |=> slot_q && upc_q == $past(upc_q) + UADDR_W'(1));
    // R8
    empty_wait_chk: assert property (@(posedge clk) disable iff (rst)
        wait_q && !fifo_has |=> wait_q);
    // R10
    redirect_clears_slot_chk: assert property (@(posedge clk) disable iff (rst)
        rd_fire |=> !slot_q && !wait_q);
endmodule

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst, stall_i, entry_valid_i, redirect_i;
    logic [7:0] cond_i;
    logic [5:0] entry_addr_i, redirect_addr_i;
    logic       entry_ready_o, uop_valid_o, slot_o;
    logic [5:0] upc_o;
    logic [36:0] uword_o;
    logic [4:0] move_src_o, move_dst_o;
    logic [2:0] alu_src_o, sub_op_o;
    logic [3:0] alu_op_o;
    logic [5:0] bus_ctl_o;

    int    errors = 0;
    int    checks = 0;
    int    expq[$];
    string tag = "R2";

    always #5 clk = ~clk;

    useq_sequencer dut_i (
        .clk(clk), .rst(rst), .stall_i(stall_i), .cond_i(cond_i),
        .entry_valid_i(entry_valid_i), .entry_addr_i(entry_addr_i),
        .entry_ready_o(entry_ready_o), .redirect_i(redirect_i),
        .redirect_addr_i(redirect_addr_i), .uop_valid_o(uop_valid_o),
        .upc_o(upc_o), .slot_o(slot_o), .uword_o(uword_o),
        .move_src_o(move_src_o), .move_dst_o(move_dst_o),
        .alu_src_o(alu_src_o), .alu_op_o(alu_op_o),
        .sub_op_o(sub_op_o), .bus_ctl_o(bus_ctl_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected item: slot flag * 64 + micro-address
    task automatic expect_op(input int a, input int s);
        expq.push_back(s * 64 + a);
    endtask

    // Monitor: pops one expected item per executed micro-op
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (!rst && uop_valid_o) begin
                int got;
                logic [5:0] a;
                logic [25:0] fexp;
                got  = int'(slot_o) * 64 + int'(upc_o);
                a    = upc_o;
                fexp = {a[4:0], ~a[4:0], a[2:0], a[3:0], a[5:3], a};
                // R1 field layout and field ports
                check(uword_o[25:0] == fexp && move_src_o == a[4:0] && move_dst_o == ~a[4:0]
                      && alu_src_o == a[2:0] && alu_op_o == a[3:0] && sub_op_o == a[5:3]
                      && bus_ctl_o == a, "R1", "field ports", int'(uword_o[25:0]), int'(fexp));
                if (expq.size() == 0) begin
                    check(1'b0, tag, "unexpected micro-op", got, -1);
                end else begin
                    int e;
                    e = expq.pop_front();
                    check(got == e, tag, "slot*64+upc", got, e);
                end
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic do_reset();
        rst = 1'b1; stall_i = 1'b1; entry_valid_i = 1'b0; redirect_i = 1'b0;
        entry_addr_i = '0; redirect_addr_i = '0;
        expq.delete();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R2 reset state
        check(upc_o == 6'd0 && !slot_o && !uop_valid_o, "R2", "reset upc", int'(upc_o), 0);
        check(entry_ready_o == 1'b1, "R2", "reset fifo ready", int'(entry_ready_o), 1);
    endtask

    task automatic push_entry(input int a);
        entry_valid_i = 1'b1;
        entry_addr_i  = 6'(a);
        @(negedge clk);
        entry_valid_i = 1'b0;
        #1;
    endtask

    task automatic wait_upc(input int a);
        int n = 0;
        #1;
        while (!(uop_valid_o && upc_o == 6'(a)) && n < 300) begin
            @(negedge clk);
            #1;
            n++;
        end
        if (n >= 300) check(1'b0, tag, "never reached upc", int'(upc_o), a);
    endtask

    task automatic raise(input int a);
        redirect_i      = 1'b1;
        redirect_addr_i = 6'(a);
        @(negedge clk);
        redirect_i = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (expq.size() != 0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        repeat (6) @(negedge clk);
        check(expq.size() == 0, tag, "expected ops left", expq.size(), 0);
        #1;
        // R8 stuck in wait with an empty FIFO
        check(!uop_valid_o, "R8", "valid while FIFO empty", int'(uop_valid_o), 0);
    endtask

    initial begin
        cond_i = 8'hFF;
        // Scenario 1: jumps, cond taken, next-entry, slot-jump, full FIFO, empty wait
        do_reset();
        tag = "R9";
        push_entry(32); push_entry(40); push_entry(32);
        check(!entry_ready_o, "R9", "ready when full", int'(entry_ready_o), 0);
        push_entry(48);
        check(!entry_ready_o, "R9", "ready after dropped push", int'(entry_ready_o), 0);
        tag = "R3 R4 R5 R6 R7 R9";
        expect_op(0,0); expect_op(1,0); expect_op(2,1); expect_op(8,0); expect_op(9,1);
        expect_op(16,0); expect_op(17,1); expect_op(32,0); expect_op(33,1);
        expect_op(40,0); expect_op(41,1); expect_op(48,0); expect_op(49,1);
        expect_op(32,0); expect_op(33,1);
        stall_i = 1'b0;
        drain();
        tag = "R8";
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk); #1;
                if (uop_valid_o) seen++;
            end
            check(seen == 0, "R8", "ops during empty wait", seen, 0);
        end
        expect_op(40,0); expect_op(41,1); expect_op(48,0); expect_op(49,1);
        push_entry(40);
        drain();

        // Scenario 2: conditional jump not taken
        do_reset();
        cond_i = 8'h00;
        push_entry(32);
        tag = "R3 R5 R6";
        expect_op(0,0); expect_op(1,0); expect_op(2,1); expect_op(8,0); expect_op(9,0);
        expect_op(10,0); expect_op(11,0); expect_op(12,1); expect_op(32,0); expect_op(33,1);
        stall_i = 1'b0;
        drain();
        cond_i = 8'hFF;

        // Scenario 3: redirect landing on a taken conditional jump
        do_reset();
        tag = "R10 R11";
        expect_op(0,0); expect_op(1,0); expect_op(2,1); expect_op(8,0);
        expect_op(60,0); expect_op(61,1);
        @(negedge clk);
        stall_i = 1'b0;
        wait_upc(0);
        raise(60);
        drain();

        // Scenario 4: redirect landing on a delay slot about to transfer
        do_reset();
        tag = "R11";
        expect_op(0,0); expect_op(1,0); expect_op(2,1); expect_op(8,0); expect_op(9,1);
        expect_op(60,0); expect_op(61,1);
        @(negedge clk);
        stall_i = 1'b0;
        wait_upc(1);
        raise(60);
        drain();

        // Scenario 5: second redirect while one is pending
        do_reset();
        tag = "R12";
        expect_op(0,0); expect_op(1,0); expect_op(2,1); expect_op(8,0);
        expect_op(60,0); expect_op(61,1);
        @(negedge clk);
        stall_i = 1'b0;
        wait_upc(0);
        raise(60);
        wait_upc(1);
        raise(40);
        drain();

        // Scenario 6: stall while a redirect countdown is pending
        do_reset();
        tag = "R13";
        expect_op(0,0); expect_op(1,0); expect_op(2,1); expect_op(8,0);
        expect_op(60,0); expect_op(61,1);
        @(negedge clk);
        stall_i = 1'b0;
        wait_upc(0);
        raise(60);
        stall_i = 1'b1;
        begin
            int bad = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk); #1;
                if (uop_valid_o || upc_o != 6'd1 || slot_o) bad++;
            end
            check(bad == 0, "R13", "state moved under stall", bad, 0);
        end
        stall_i = 1'b0;
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule